// File: doc/BRIEF.md
# Configurable-Mode GPIO Port Controller

This block controls an eight-pin general-purpose port. Each pin has a 2-bit drive-mode field, and the eight fields are split across two configuration registers. The mode can be quasi-bidirectional, push-pull, open-drain or input-only. The field and the pin's output latch bit together set three pad-control enables for that pin: a strong pull-down, a strong pull-up and a weak pull-up. The enables are decoded straight from the registered configuration and latch, so a register write shows up at the pad controls in the cycle after the write edge.

On the input side, each pad level passes through a two-flop synchronizer and then a digital glitch filter. The filter accepts a new level only once it has held for three consecutive sampled clocks. The filtered levels of all eight pins can be read as one byte. Filtering runs in every drive mode, including input-only. The analog behaviour of the pads is outside this block, so software and the pad ring see only registered, deterministic controls.

Top module: `gpio_mode_port`

## Requirements
- R1: Configuration register 0 holds pins 0 to 3 and register 1 holds pins 4 to 7. Pin k of a register sits at bits [2k+1:2k]. Asserting cfg_we[j] loads cfg_wdata into register j at the clock edge. Mode codes: 00 quasi-bidirectional, 01 input-only, 10 push-pull, 11 open-drain.
- R2: In quasi-bidirectional mode, a latch bit of 1 enables only the weak pull-up, and a latch bit of 0 enables only the strong pull-down.
- R3: In push-pull mode, a latch bit of 1 enables only the strong pull-up, and a latch bit of 0 enables only the strong pull-down.
- R4: In open-drain mode, a latch bit of 1 enables no driver at all, and a latch bit of 0 enables only the strong pull-down.
- R5: In input-only mode, no driver enable is ever set, whatever the latch bit.
- R6: For each pin, at most one of sink_en, src_strong_en and src_weak_en is high at any time.
- R7: Asserting latch_we loads latch_wdata into the output latch at the clock edge, with bit i belonging to pin i. The new drive is visible in the next cycle.
- R8: After reset, all mode fields are 00 and all latch bits are 1, so only the weak pull-ups are on. in_state reads 0xFF.
- R9: A pad level change appears on in_state on the fifth rising edge after it is applied: two synchronizer stages plus three stable samples. After four edges, in_state still holds the old level.
- R10: A pad pulse lasting one or two clock cycles never reaches in_state. A pulse lasting three cycles is accepted.
- R11: The input filter works the same in every drive mode. in_state carries the filtered level of pin i in bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 2 | Per-register write strobe for the mode registers |
| cfg_wdata | input | 8 | Mode register write data, four 2-bit fields |
| latch_we | input | 1 | Output latch write strobe |
| latch_wdata | input | 8 | Output latch write data, bit i for pin i |
| pad_in | input | 8 | Raw pad input levels |
| sink_en | output | 8 | Strong pull-down enable per pin |
| src_strong_en | output | 8 | Strong pull-up enable per pin |
| src_weak_en | output | 8 | Weak pull-up enable per pin |
| in_state | output | 8 | Filtered input level per pin |

## Verification
The hardest case to reach from the ports is the exact edge at which the filter gives way. A pulse one cycle too short must leave no trace, and a pulse just long enough must land on a known edge even though the synchronizer hides the filter's counter. The stimulus drives pad changes at the falling edge. It applies pulses lasting one, two and three cycles and samples in_state on the fourth and fifth rising edges after each change. It also repeats level steps with every drive mode loaded, to show the filter does not depend on the mode. The drive decode is swept over all 256 values of one mode register, with the other register holding a scrambled copy, and under several latch patterns.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;

  typedef enum logic [1:0] {
    PM_QUASI = 2'b00,
    PM_INPUT = 2'b01,
    PM_PUSH  = 2'b10,
    PM_OPEN  = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic sink;
    logic src_strong;
    logic src_weak;
  } drive_t;

  // Pad drive for one pin from its mode and latch bit
  function automatic drive_t drive_for(pin_mode_e mode, logic lat);
    drive_t d;
    d = '0;
    unique case (mode)
      PM_QUASI: begin
        d.src_weak = lat;
        d.sink     = ~lat;
      end
      PM_PUSH: begin
        d.src_strong = lat;
        d.sink       = ~lat;
      end
      PM_OPEN:  d.sink = ~lat;
      PM_INPUT: d = '0;
      default:  d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
  parameter int NUM_PINS     = 8,
  parameter int PINS_PER_REG = 4,
  localparam int NUM_REGS    = NUM_PINS / PINS_PER_REG,
  localparam int REG_W       = 2 * PINS_PER_REG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_REGS-1:0]   cfg_we,
  input  logic [REG_W-1:0]      cfg_wdata,
  input  logic                  latch_we,
  input  logic [NUM_PINS-1:0]   latch_wdata,
  output logic [2*NUM_PINS-1:0] mode_flat,
  output logic [NUM_PINS-1:0]   latch_q
);

  logic [NUM_REGS-1:0][REG_W-1:0] cfg_q;

  for (genvar j = 0; j < NUM_REGS; j++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q[j] <= '0;
      else if (cfg_we[j]) cfg_q[j] <= cfg_wdata;
    end
  end

  // register j, field k -> pin j*PINS_PER_REG + k at flat bits 2*pin
  assign mode_flat = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '1;
    else if (latch_we) latch_q <= latch_wdata;
  end

endmodule

// File: rtl/gpio_drive_decode.sv
module gpio_drive_decode
  import gpio_mode_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic [2*NUM_PINS-1:0] mode_flat,
  input  logic [NUM_PINS-1:0]   latch_q,
  output logic [NUM_PINS-1:0]   sink_en,
  output logic [NUM_PINS-1:0]   src_strong_en,
  output logic [NUM_PINS-1:0]   src_weak_en
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    drive_t drv;
    assign drv = drive_for(pin_mode_e'(mode_flat[2*i +: 2]), latch_q[i]);
    assign sink_en[i]       = drv.sink;
    assign src_strong_en[i] = drv.src_strong;
    assign src_weak_en[i]   = drv.src_weak;
  end

endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 3,
  localparam int CNT_W      = $clog2(FILT_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] sync_q,
  output logic [NUM_PINS-1:0] accept_evt,
  output logic [NUM_PINS-1:0] filt_q
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FILT_DEPTH - 1);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] pipe;
    logic [CNT_W-1:0]       cnt;
    logic                   differs;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[SYNC_STAGES-2:0], pad_in[i]};
    end

    assign sync_q[i]     = pipe[SYNC_STAGES-1];
    assign differs       = sync_q[i] ^ filt_q[i];
    assign accept_evt[i] = differs && (cnt == LAST_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt       <= '0;
        filt_q[i] <= 1'b1;
      end else if (accept_evt[i]) begin
        cnt       <= '0;
        filt_q[i] <= sync_q[i];
      end else if (differs) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port #(
  parameter int NUM_PINS      = 8,
  parameter int PINS_PER_REG  = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int FILT_DEPTH    = 3,
  localparam int NUM_CFG_REGS = NUM_PINS / PINS_PER_REG,
  localparam int CFG_REG_W    = 2 * PINS_PER_REG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CFG_REGS-1:0] cfg_we,
  input  logic [CFG_REG_W-1:0]    cfg_wdata,
  input  logic                    latch_we,
  input  logic [NUM_PINS-1:0]     latch_wdata,
  input  logic [NUM_PINS-1:0]     pad_in,
  output logic [NUM_PINS-1:0]     sink_en,
  output logic [NUM_PINS-1:0]     src_strong_en,
  output logic [NUM_PINS-1:0]     src_weak_en,
  output logic [NUM_PINS-1:0]     in_state
);

  logic [2*NUM_PINS-1:0] mode_flat;
  logic [NUM_PINS-1:0]   latch_q;
  logic [NUM_PINS-1:0]   sync_q;
  logic [NUM_PINS-1:0]   accept_evt;

  gpio_cfg_regs #(
    .NUM_PINS    (NUM_PINS),
    .PINS_PER_REG(PINS_PER_REG)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .latch_we   (latch_we),
    .latch_wdata(latch_wdata),
    .mode_flat  (mode_flat),
    .latch_q    (latch_q)
  );

  gpio_drive_decode #(
    .NUM_PINS(NUM_PINS)
  ) i_decode (
    .mode_flat    (mode_flat),
    .latch_q      (latch_q),
    .sink_en      (sink_en),
    .src_strong_en(src_strong_en),
    .src_weak_en  (src_weak_en)
  );

  gpio_glitch_filter #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_DEPTH (FILT_DEPTH)
  ) i_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_in    (pad_in),
    .sync_q    (sync_q),
    .accept_evt(accept_evt),
    .filt_q    (in_state)
  );

endmodule

// File: rtl/gpio_mode_port_chk.sv
module gpio_mode_port_chk #(
  parameter int NUM_PINS   = 8,
  parameter int FILT_DEPTH = 3,
  localparam int RUN_W     = $clog2(FILT_DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2*NUM_PINS-1:0] mode_flat,
  input logic [NUM_PINS-1:0]   latch_q,
  input logic                  latch_we,
  input logic [NUM_PINS-1:0]   latch_wdata,
  input logic [NUM_PINS-1:0]   sync_q,
  input logic [NUM_PINS-1:0]   accept_evt,
  input logic [NUM_PINS-1:0]   in_state,
  input logic [NUM_PINS-1:0]   sink_en,
  input logic [NUM_PINS-1:0]   src_strong_en,
  input logic [NUM_PINS-1:0]   src_weak_en
);

  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FILT_DEPTH);

  // R7
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_we |=> latch_q == $past(latch_wdata));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0]       m;
    logic [RUN_W-1:0] run_len;
    logic             last_s;

    assign m = mode_flat[2*i +: 2];

    // how many consecutive edges the synchronized level has been sampled
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_s  <= 1'b1;
        run_len <= RUN_MAX;
      end else begin
        last_s <= sync_q[i];
        if (sync_q[i] != last_s) run_len <= RUN_W'(1);
        else if (run_len != RUN_MAX) run_len <= run_len + 1'b1;
      end
    end

    // R6
    single_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sink_en[i], src_strong_en[i], src_weak_en[i]}));

    // R5
    input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b01) |-> !(sink_en[i] || src_strong_en[i] || src_weak_en[i]));

    // R2
    quasi_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b00) |-> (src_weak_en[i] == latch_q[i]) && (sink_en[i] == !latch_q[i])
                       && !src_strong_en[i]);

    // R3
    push_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b10) |-> (src_strong_en[i] == latch_q[i]) && (sink_en[i] == !latch_q[i]));

    // R4
    open_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b11) |-> !src_strong_en[i] && !src_weak_en[i] && (sink_en[i] == !latch_q[i]));

    // R9
    filter_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_state[i] != $past(in_state[i])) |-> (run_len >= RUN_MAX) && (last_s == in_state[i]));

    // R10
    accept_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_evt[i] |=> in_state[i] != $past(in_state[i]));
  end

endmodule

bind gpio_mode_port gpio_mode_port_chk #(
  .NUM_PINS  (NUM_PINS),
  .FILT_DEPTH(FILT_DEPTH)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_flat    (mode_flat),
  .latch_q      (latch_q),
  .latch_we     (latch_we),
  .latch_wdata  (latch_wdata),
  .sync_q       (sync_q),
  .accept_evt   (accept_evt),
  .in_state     (in_state),
  .sink_en      (sink_en),
  .src_strong_en(src_strong_en),
  .src_weak_en  (src_weak_en)
);

// File: tb/test_gpio_mode_port.sv
`timescale 1ns/1ps
module test_gpio_mode_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_we = '0;
  logic [7:0] cfg_wdata = '0;
  logic       latch_we = 1'b0;
  logic [7:0] latch_wdata = '0;
  logic [7:0] pad_in = 8'hFF;
  logic [7:0] sink_en, src_strong_en, src_weak_en, in_state;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_mode_port i_gpio_mode_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .latch_we     (latch_we),
    .latch_wdata  (latch_wdata),
    .pad_in       (pad_in),
    .sink_en      (sink_en),
    .src_strong_en(src_strong_en),
    .src_weak_en  (src_weak_en),
    .in_state     (in_state)
  );

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write_cfg(int idx, logic [7:0] v);
    cfg_we[idx] = 1'b1;
    cfg_wdata   = v;
    @(posedge clk); @(negedge clk);
    cfg_we = '0;
  endtask

  task automatic write_latch(logic [7:0] v);
    latch_we    = 1'b1;
    latch_wdata = v;
    @(posedge clk); @(negedge clk);
    latch_we = 1'b0;
  endtask

  // mode of pin p given register contents (R1 layout)
  function automatic int pin_mode(logic [7:0] r0, logic [7:0] r1, int p);
    logic [7:0] r;
    r = (p < 4) ? r0 : r1;
    return int'((r >> (2 * (p % 4))) & 8'h03);
  endfunction

  // step: old level holds through edge 4, new appears after edge 5 (R9)
  task automatic step_check(string tag, logic [7:0] old_v, logic [7:0] new_v);
    pad_in = new_v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check8({tag, " R9 hold after 4 edges"}, in_state, old_v);
    @(posedge clk); @(negedge clk);
    check8({tag, " R9 accept at edge 5"}, in_state, new_v);
  endtask

  initial begin
    int unsigned wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog R9: actual hung run, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55; pats[3] = 8'hA3;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check8("R8 sink", sink_en, 8'h00);
    check8("R8 strong", src_strong_en, 8'h00);
    check8("R8 weak", src_weak_en, 8'hFF);
    check8("R8 in_state", in_state, 8'hFF);

    // R7 latch write visible next cycle, quasi mode
    write_latch(8'h5A);
    check8("R7 weak after latch write", src_weak_en, 8'h5A);
    check8("R7 sink after latch write", sink_en, 8'hA5);

    // Exhaustive decode sweep: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 256; v++) begin
      logic [7:0] r0, r1;
      r0 = 8'(v);
      r1 = 8'(v) ^ 8'hA5;
      write_cfg(0, r0);
      write_cfg(1, r1);
      for (int p = 0; p < 4; p++) begin
        logic [7:0] ed, es, ew;
        write_latch(pats[p]);
        for (int b = 0; b < 8; b++) begin
          int md;
          md = pin_mode(r0, r1, b);
          ed[b] = (md != 1) && !pats[p][b];
          es[b] = (md == 2) && pats[p][b];
          ew[b] = (md == 0) && pats[p][b];
        end
        check8("R1/R2/R3/R4/R5 sink_en", sink_en, ed);
        check8("R1/R2/R3/R4 src_strong_en", src_strong_en, es);
        check8("R1/R2/R5 src_weak_en", src_weak_en, ew);
        check8("R6 overlap", (sink_en & src_strong_en) | (sink_en & src_weak_en)
                             | (src_strong_en & src_weak_en), 8'h00);
      end
    end

    // Filter in each drive mode (R9, R11)
    write_cfg(0, 8'h00); write_cfg(1, 8'h00);
    write_latch(8'hFF);
    step_check("R11 quasi", 8'hFF, 8'h3C);
    write_cfg(0, 8'h55); write_cfg(1, 8'h55);
    step_check("R11 input-only", 8'h3C, 8'h81);
    write_cfg(0, 8'hAA); write_cfg(1, 8'hAA);
    write_latch(8'h00);
    step_check("R11 push-pull", 8'h81, 8'h01);
    write_cfg(0, 8'hFF); write_cfg(1, 8'hFF);
    step_check("R11 open-drain", 8'h01, 8'h80);
    step_check("R11 bit order", 8'h80, 8'h3C);

    // Glitch rejection (R10)
    for (int w = 1; w <= 2; w++) begin
      pad_in = 8'hC3;
      repeat (w) @(negedge clk);
      pad_in = 8'h3C;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check8("R10 short pulse at edge 5", in_state, 8'h3C);
      repeat (6) @(negedge clk);
      check8("R10 short pulse settled", in_state, 8'h3C);
    end
    pad_in = 8'h0F;
    repeat (3) @(negedge clk);
    pad_in = 8'h3C;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check8("R10 three-cycle pulse accepted", in_state, 8'h0F);
    repeat (8) @(negedge clk);
    check8("R10 level returns after pulse", in_state, 8'h3C);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule